// File: doc/BRIEF.md
# Protected Flash Block Controller

This block sits in front of a word-addressed flash array, modelled here as a register memory inside the block. It takes requests from two ports. The data port can read a word, program a word or erase a whole erase block. The instruction-fetch port can only read. Every request is checked against a protection table before it takes effect. A refused request leaves the memory unchanged and raises an access-violation signal.

The array is split into `NUM_BLOCKS` erase blocks of `BLK_WORDS` words each. The defaults are 96 blocks of 8 words, a scaled-down stand-in for 96 one-kilobyte blocks. Erasing a block sets every bit in it to 1. Programming can only clear bits: the stored word becomes the old word AND the written data.

Protection is assigned per region, where a region is a pair of neighbouring erase blocks. The region number is the erase block number shifted right by one. Each region is in one of three modes: open, read-only or execute-only. Software can change a region's mode only toward more restriction, and only a reset loosens it again.

Program and erase hold `busy` for a fixed, parameterized number of cycles and then pulse `done`.

Top module: `flashctl_top`

## Requirements
- R1: After reset, `busy`, `done`, `viol_irq` and `viol_sticky` are 0, every region reads back mode 0 (open), and every word reads as all ones.
- R2: A granted program (`d_cmd`=1) changes the addressed word to its old value AND `d_wdata`, so bits can be cleared but never set.
- R3: A granted erase (`d_cmd`=2) sets to all ones every word of the erase block that holds `d_addr` (word address bits above the low log2(`BLK_WORDS`) bits), and no word outside that block.
- R4: A granted program holds `busy` high for exactly `PROG_CYC` cycles and a granted erase for exactly `ERASE_CYC` cycles, starting the cycle after the request. `done` is high for one cycle right after `busy` falls.
- R5: While `busy` is high, every request on either port is ignored: no read response, no memory change, no violation. Command code 3 is also ignored.
- R6: In a read-only region (mode 1), program and erase are refused and the memory is unchanged, while data reads still return the stored word.
- R7: In an execute-only region (mode 2), program and erase are refused, and a data-port read returns zero and counts as a violation. A fetch-port read of the same word returns the stored word.
- R8: A protection write (`prot_we`, `prot_wr_region`, `prot_wr_mode`) takes effect only if the new mode is 0, 1 or 2 and numerically greater than the current one. Mode 3 and downgrades are ignored.
- R9: Both erase blocks of a region (block numbers 2k and 2k+1) follow region k's mode, and the mode of one region does not affect its neighbours.
- R10: A refused request pulses `viol_irq` in the cycle after the request and sets `viol_sticky`, which stays 1 until reset.
- R11: An address at or beyond `NUM_BLOCKS*BLK_WORDS` is refused on either port, and a refused read returns zero.
- R12: A read request accepted on either port is answered with `*_rvalid` high for one cycle in the next cycle, with the data on `*_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| d_req | input | 1 | Data-port request strobe |
| d_cmd | input | 2 | 0 read, 1 program, 2 erase, 3 ignored |
| d_addr | input | AW | Data-port word address |
| d_wdata | input | DW | Program data |
| d_rdata | output | DW | Data-port read data |
| d_rvalid | output | 1 | Data-port read response valid |
| f_req | input | 1 | Fetch read request strobe |
| f_addr | input | AW | Fetch word address |
| f_rdata | output | DW | Fetch read data |
| f_rvalid | output | 1 | Fetch read response valid |
| prot_we | input | 1 | Protection write strobe |
| prot_wr_region | input | RW | Region to restrict |
| prot_wr_mode | input | 2 | Requested mode: 0 open, 1 read-only, 2 execute-only |
| prot_rd_region | input | RW | Region selected for read-back |
| prot_rd_mode | output | 2 | Current mode of the selected region |
| busy | output | 1 | Program or erase in progress |
| done | output | 1 | One-cycle completion pulse |
| viol_irq | output | 1 | One-cycle pulse per refused request |
| viol_sticky | output | 1 | Latched violation status |

## Verification
The checker watches these rules on every cycle:
- `done` follows every fall of `busy` and is never high together with it.
- A violation pulse always comes with the sticky status, and the sticky status never drops.
- A read response only follows a request made one cycle before, on that same port, while the block was idle.
- The mode read back for a held region never loosens.

The bench scenarios are needed for the rest:
- the AND-only programming result;
- the exact reach of an erase and the exact busy length;
- the region-pair mapping;
- the split behaviour of execute-only regions between the two ports;
- the handling of out-of-range addresses.

The bench checks these against its own memory and protection model.

// File: rtl/flashctl_pkg.sv
package flashctl_pkg;
   typedef enum logic [1:0] {
      PROT_OPEN   = 2'd0,
      PROT_RDONLY = 2'd1,
      PROT_XONLY  = 2'd2,
      PROT_BAD    = 2'd3
   } prot_mode_t;

   typedef enum logic [1:0] {
      OP_READ  = 2'd0,
      OP_PROG  = 2'd1,
      OP_ERASE = 2'd2,
      OP_NONE  = 2'd3
   } flash_op_t;
endpackage

// File: rtl/flashctl_prot_table.sv
module flashctl_prot_table
   import flashctl_pkg::*;
#(
   parameter int NREG = 48,
   parameter int RW   = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [RW-1:0] wr_idx,
   input  logic [1:0]    wr_mode,
   input  logic [RW-1:0] a_idx,
   output logic [1:0]    a_mode,
   input  logic [RW-1:0] b_idx,
   output logic [1:0]    b_mode
);
   logic [1:0] modes [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic [1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= PROT_OPEN;
         else if (we && wr_idx == RW'(g) && wr_mode != PROT_BAD && wr_mode > q)
            q <= wr_mode;
      end
      assign modes[g] = q;
   end

   // Indices past the table select the most restrictive mode.
   always_comb begin
      a_mode = PROT_XONLY;
      b_mode = PROT_XONLY;
      if (32'(a_idx) < NREG) a_mode = modes[a_idx];
      if (32'(b_idx) < NREG) b_mode = modes[b_idx];
   end
endmodule

// File: rtl/flashctl_gate.sv
module flashctl_gate
   import flashctl_pkg::*;
(
   input  logic       req,
   input  logic       fetch,
   input  logic [1:0] op,
   input  logic       in_range,
   input  logic [1:0] mode,
   output logic       grant,
   output logic       deny
);
   always_comb begin
      grant = 1'b0;
      deny  = 1'b0;
      if (req) begin
         unique case (op)
            OP_READ: begin
               if (in_range && (fetch || mode != PROT_XONLY)) grant = 1'b1;
               else deny = 1'b1;
            end
            OP_PROG, OP_ERASE: begin
               if (!fetch) begin
                  if (in_range && mode == PROT_OPEN) grant = 1'b1;
                  else deny = 1'b1;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/flashctl_timer.sv
module flashctl_timer #(
   parameter int PROG_CYC  = 4,
   parameter int ERASE_CYC = 12,
   parameter int BLK_WORDS = 8,
   localparam int BW = $clog2(BLK_WORDS),
   localparam int CW = $clog2((PROG_CYC > ERASE_CYC ? PROG_CYC : ERASE_CYC) + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          is_erase,
   output logic          busy,
   output logic          done,
   output logic          step_en,
   output logic [BW-1:0] step_idx
);
   logic [CW-1:0] cnt;
   logic          er_q;
   logic [BW:0]   step;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
         cnt  <= '0;
         er_q <= 1'b0;
         step <= '0;
      end else begin
         done <= 1'b0;
         if (start) begin
            busy <= 1'b1;
            cnt  <= is_erase ? CW'(ERASE_CYC - 1) : CW'(PROG_CYC - 1);
            er_q <= is_erase;
            step <= '0;
         end else if (busy) begin
            if (cnt == '0) begin
               busy <= 1'b0;
               done <= 1'b1;
               er_q <= 1'b0;
            end else begin
               cnt <= cnt - 1'b1;
            end
            if (step_en) step <= step + 1'b1;
         end
      end
   end

   // Erase clears one word per busy cycle until the block is covered.
   assign step_en  = busy && er_q && (32'(step) < BLK_WORDS);
   assign step_idx = step[BW-1:0];
endmodule

// File: rtl/flashctl_top.sv
module flashctl_top
   import flashctl_pkg::*;
#(
   parameter int NUM_BLOCKS = 96,
   parameter int BLK_WORDS  = 8,
   parameter int DW         = 32,
   parameter int PROG_CYC   = 4,
   parameter int ERASE_CYC  = 12,
   localparam int TOTAL = NUM_BLOCKS * BLK_WORDS,
   localparam int AW    = $clog2(TOTAL),
   localparam int BW    = $clog2(BLK_WORDS),
   localparam int NREG  = NUM_BLOCKS / 2,
   localparam int RW    = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          d_req,
   input  logic [1:0]    d_cmd,
   input  logic [AW-1:0] d_addr,
   input  logic [DW-1:0] d_wdata,
   output logic [DW-1:0] d_rdata,
   output logic          d_rvalid,
   input  logic          f_req,
   input  logic [AW-1:0] f_addr,
   output logic [DW-1:0] f_rdata,
   output logic          f_rvalid,
   input  logic          prot_we,
   input  logic [RW-1:0] prot_wr_region,
   input  logic [1:0]    prot_wr_mode,
   input  logic [RW-1:0] prot_rd_region,
   output logic [1:0]    prot_rd_mode,
   output logic          busy,
   output logic          done,
   output logic          viol_irq,
   output logic          viol_sticky
);
   if (NUM_BLOCKS < 4 || NUM_BLOCKS % 2 != 0) begin : g_bad_blocks
      $error("NUM_BLOCKS must be even and at least 4");
   end
   if (BLK_WORDS < 2 || (1 << BW) != BLK_WORDS) begin : g_bad_words
      $error("BLK_WORDS must be a power of two, at least 2");
   end
   if (PROG_CYC < 1 || ERASE_CYC < BLK_WORDS) begin : g_bad_cyc
      $error("PROG_CYC must be >= 1 and ERASE_CYC >= BLK_WORDS");
   end

   logic [DW-1:0]    mem [TOTAL];
   logic [AW-BW-1:0] d_blk, er_blk;
   logic [RW-1:0]    d_reg;
   logic [1:0]       d_mode;
   logic             d_inr, f_inr, d_live, f_live;
   logic             d_grant, d_deny, f_grant, f_deny;
   logic             t_start, step_en;
   logic [BW-1:0]    step_idx;

   assign d_blk  = d_addr[AW-1:BW];
   assign d_reg  = RW'(d_blk >> 1);
   assign d_inr  = {1'b0, d_addr} < (AW+1)'(TOTAL);
   assign f_inr  = {1'b0, f_addr} < (AW+1)'(TOTAL);
   assign d_live = d_req && !busy;
   assign f_live = f_req && !busy;

   flashctl_prot_table #(.NREG(NREG), .RW(RW)) u_prot (
      .clk, .rst_n,
      .we(prot_we), .wr_idx(prot_wr_region), .wr_mode(prot_wr_mode),
      .a_idx(d_reg), .a_mode(d_mode),
      .b_idx(prot_rd_region), .b_mode(prot_rd_mode)
   );

   flashctl_gate u_dgate (
      .req(d_live), .fetch(1'b0), .op(d_cmd), .in_range(d_inr),
      .mode(d_mode), .grant(d_grant), .deny(d_deny)
   );

   flashctl_gate u_fgate (
      .req(f_live), .fetch(1'b1), .op(OP_READ), .in_range(f_inr),
      .mode(PROT_XONLY), .grant(f_grant), .deny(f_deny)
   );

   assign t_start = d_grant && (d_cmd == OP_PROG || d_cmd == OP_ERASE);

   flashctl_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .BLK_WORDS(BLK_WORDS)) u_tmr (
      .clk, .rst_n, .start(t_start), .is_erase(d_cmd == OP_ERASE),
      .busy, .done, .step_en, .step_idx
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < TOTAL; i++) mem[i] <= '1;
         er_blk <= '0;
      end else if (t_start && d_cmd == OP_PROG) begin
         mem[d_addr] <= mem[d_addr] & d_wdata;
      end else if (t_start) begin
         er_blk <= d_blk;
      end else if (step_en) begin
         mem[{er_blk, step_idx}] <= '1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         d_rvalid    <= 1'b0;
         f_rvalid    <= 1'b0;
         d_rdata     <= '0;
         f_rdata     <= '0;
         viol_irq    <= 1'b0;
         viol_sticky <= 1'b0;
      end else begin
         d_rvalid    <= d_live && d_cmd == OP_READ;
         f_rvalid    <= f_live;
         d_rdata     <= (d_grant && d_cmd == OP_READ) ? mem[d_addr] : '0;
         f_rdata     <= f_grant ? mem[f_addr] : '0;
         viol_irq    <= d_deny || f_deny;
         viol_sticky <= viol_sticky || d_deny || f_deny;
      end
   end
endmodule

// File: rtl/flashctl_chk.sv
module flashctl_chk #(
   parameter int RW = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          done,
   input logic          viol_irq,
   input logic          viol_sticky,
   input logic          d_req,
   input logic          d_rvalid,
   input logic          f_req,
   input logic          f_rvalid,
   input logic [RW-1:0] prot_rd_region,
   input logic [1:0]    prot_rd_mode
);
   // R4
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
   // R4
   done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R10
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      viol_sticky |=> viol_sticky);
   // R10
   irq_sets_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      viol_irq |-> viol_sticky);
   // R12
   d_rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      d_rvalid |-> $past(d_req));
   // R12
   f_rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      f_rvalid |-> $past(f_req));
   // R5
   no_resp_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (d_rvalid || f_rvalid) |-> !$past(busy));
   // R8
   prot_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(prot_rd_region) |-> prot_rd_mode >= $past(prot_rd_mode));
endmodule

bind flashctl_top flashctl_chk #(.RW(RW)) u_chk (.*);

// File: tb/sim_flashctl_top.sv
module sim_flashctl_top;
   localparam int NB = 96, BWD = 8, PC = 4, EC = 12;
   localparam int TOT = NB * BWD;

   logic clk = 1'b0, rst_n = 1'b0;
   logic d_req = 0, f_req = 0, prot_we = 0;
   logic [1:0] d_cmd = 0, prot_wr_mode = 0, prot_rd_mode;
   logic [9:0] d_addr = 0, f_addr = 0;
   logic [31:0] d_wdata = 0, d_rdata, f_rdata;
   logic [5:0] prot_wr_region = 0, prot_rd_region = 0;
   logic d_rvalid, f_rvalid, busy, done, viol_irq, viol_sticky;

   int errs = 0, checks = 0;
   logic [31:0] mref [TOT];
   logic [1:0]  pref [NB/2];

   always #2 clk = ~clk;

   flashctl_top #(.NUM_BLOCKS(NB), .BLK_WORDS(BWD), .DW(32), .PROG_CYC(PC), .ERASE_CYC(EC)) u0 (.*);

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [1:0] mode_of(int a);
      return pref[(a / BWD) / 2];
   endfunction

   task automatic op_read(int a, string req);
      logic [31:0] exp; bit bad;
      bad = (a >= TOT) || mode_of(a % TOT) == 2'd2;
      exp = bad ? 32'h0 : mref[a];
      d_req = 1; d_cmd = 0; d_addr = 10'(a);
      @(negedge clk); d_req = 0;
      chk(d_rvalid === 1'b1, "R12", 32'(d_rvalid), 1);
      chk(d_rdata === exp, req, d_rdata, exp);
      chk(viol_irq === bad, "R10", 32'(viol_irq), 32'(bad));
   endtask

   task automatic op_fetch(int a);
      logic [31:0] exp; bit bad;
      bad = a >= TOT;
      exp = bad ? 32'h0 : mref[a];
      f_req = 1; f_addr = 10'(a);
      @(negedge clk); f_req = 0;
      chk(f_rvalid === 1'b1, "R12", 32'(f_rvalid), 1);
      chk(f_rdata === exp, "R7", f_rdata, exp);
      chk(viol_irq === bad, "R11", 32'(viol_irq), 32'(bad));
   endtask

   task automatic op_write(int a, bit erase, logic [31:0] data);
      bit ok; int n;
      ok = (a < TOT) && mode_of(a % TOT) == 2'd0;
      d_req = 1; d_cmd = erase ? 2'd2 : 2'd1; d_addr = 10'(a); d_wdata = data;
      @(negedge clk); d_req = 0;
      if (ok) begin
         n = 0;
         while (busy === 1'b1 && n < 100) begin n++; @(negedge clk); end
         chk(n == (erase ? EC : PC), "R4", 32'(n), erase ? EC : PC);
         chk(done === 1'b1, "R4", 32'(done), 1);
         if (erase) for (int i = 0; i < BWD; i++) mref[(a / BWD) * BWD + i] = '1;
         else mref[a] = mref[a] & data;
      end else begin
         chk(busy === 1'b0 && viol_irq === 1'b1, "R6", {busy, viol_irq}, 32'b01);
      end
   endtask

   task automatic op_prot(int r, logic [1:0] m);
      prot_we = 1; prot_wr_region = 6'(r); prot_wr_mode = m;
      @(negedge clk); prot_we = 0;
      if (m != 2'd3 && m > pref[r]) pref[r] = m;
      prot_rd_region = 6'(r); #1;
      chk(prot_rd_mode === pref[r], "R8", 32'(prot_rd_mode), 32'(pref[r]));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errs++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      for (int i = 0; i < TOT; i++) mref[i] = '1;
      for (int i = 0; i < NB/2; i++) pref[i] = 2'd0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: reset state
      chk({busy, done, viol_irq, viol_sticky} === 4'b0, "R1", {busy, done, viol_irq, viol_sticky}, 0);
      prot_rd_region = 6'd47; #1;
      chk(prot_rd_mode === 2'd0, "R1", 32'(prot_rd_mode), 0);
      op_read(0, "R1");
      op_read(TOT - 1, "R1");
      // R2: programming only clears bits
      op_write(5, 0, 32'hF0F0_F0F0);
      op_write(5, 0, 32'h0FF0_FFFF);
      op_read(5, "R2");
      chk(mref[5] == 32'h00F0_F0F0, "R2", mref[5], 32'h00F0_F0F0);
      // R3: erase covers one block only
      op_write(8, 0, 32'h1234_0000);
      op_write(3, 1, 0);
      for (int i = 0; i < BWD; i++) op_read(i, "R3");
      op_read(8, "R3");
      // R5: requests while busy are ignored
      d_req = 1; d_cmd = 2'd1; d_addr = 10'd20; d_wdata = 0;
      @(negedge clk);
      d_addr = 10'd21; f_req = 1; f_addr = 10'd21;
      @(negedge clk);
      d_req = 0; f_req = 0;
      chk(viol_irq === 0 && f_rvalid === 0, "R5", {viol_irq, f_rvalid}, 0);
      mref[20] = 0;
      while (busy === 1'b1) @(negedge clk);
      op_read(21, "R5");
      op_read(20, "R5");
      d_req = 1; d_cmd = 2'd3; d_addr = 10'd22; @(negedge clk); d_req = 0;
      chk(busy === 0 && viol_irq === 0 && d_rvalid === 0, "R5", {busy, viol_irq, d_rvalid}, 0);
      // R6 and R9: read-only region 1 covers words 16..31
      op_prot(1, 2'd1);
      op_write(24, 0, 0);
      op_write(16, 1, 0);
      op_read(24, "R6");
      op_read(20, "R9");
      op_write(12, 0, 32'h0000_FFFF);
      op_read(12, "R9");
      // R7: execute-only region 2 covers words 32..47
      op_write(40, 0, 32'hCAFE_F00D);
      op_prot(2, 2'd2);
      op_read(40, "R7");
      op_fetch(40);
      op_write(33, 1, 0);
      // R8: no downgrade, no mode 3, upgrade accepted
      op_prot(2, 2'd0);
      op_prot(3, 2'd3);
      op_prot(1, 2'd2);
      // R11: out of range
      op_read(800, "R11");
      op_fetch(900);
      op_write(1000, 0, 0);
      op_write(770, 1, 0);
      // R10: sticky remains
      chk(viol_sticky === 1'b1, "R10", 32'(viol_sticky), 1);
      // mixed random traffic against the model
      for (int k = 0; k < 400; k++) begin
         int kind, a;
         kind = $urandom_range(0, 15);
         a = $urandom_range(0, 799);
         if (kind == 0) op_prot($urandom_range(4, 47), 2'($urandom_range(0, 3)));
         else if (kind < 6) op_read(a, "R2");
         else if (kind < 9) op_fetch(a);
         else if (kind < 14) op_write(a, 0, $urandom);
         else op_write(a, 1, 0);
      end
      chk(viol_sticky === 1'b1, "R10", 32'(viol_sticky), 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule